// File: doc/BRIEF.md
# Four-Bit ALU Slice with Group Lookahead

This block is a combinational arithmetic logic unit slice. It takes two operand words and a four-bit function code. A mode bit chooses between sixteen bitwise logic functions and sixteen arithmetic functions. In arithmetic mode every function has the form X plus Y plus carry-in. Per bit, X and Y are simple terms of the two operand bits chosen by the code. A carry ripples through every bit position to a carry output.

The slice also exports a group generate and a group propagate signal. Both are formed from the per-bit X/Y terms, and neither depends on the carry input. An external second-order lookahead unit can use them to form the carry into each slice of a long word without waiting for the ripple. The slice width is a parameter; the default is four bits.

Top module: `alu4_lookahead`

## Requirements
- R1: With mode_i = 1 (logic mode), each result bit f_o[i] equals sel_i[2*a_i[i] + b_i[i]]. The code is therefore a truth table: sel_i = 0000 gives all zeros, 1111 gives all ones, 1100 gives A and 1010 gives B.
- R2: In logic mode, carry_i has no effect on f_o, and carry_o is 0.
- R3: With mode_i = 0 (arithmetic mode), f_o is the low bits of X + Y + carry_i. The per-code terms (X, Y) are: 0000 (A,0), 0001 (A|B,0), 0010 (A|~B,0), 0011 (A,A), 0100 (A,A&B), 0101 (A|B,A&B), 0110 (A,B), 0111 (A,A&~B), 1000 (A|B,A&~B), 1001 (A,~B), 1010 (A|~B,A&B), 1011 (A&B,all ones), 1100 (0,all ones), 1101 (A&~B,all ones), 1110 (A|~B,A), 1111 (A,all ones).
- R4: With carry_i = 0 in arithmetic mode, these codes give the named results modulo 2^WIDTH: 0110 A plus B, 1001 A minus B minus 1, 0011 A times 2, 1100 minus one (all ones), 1111 A minus 1.
- R5: In arithmetic mode, carry_o is bit WIDTH of X + Y + carry_i.
- R6: In either mode, grp_gen_o equals bit WIDTH of X + Y with no carry-in. It does not depend on carry_i.
- R7: In either mode, grp_prop_o is 1 exactly when X_i | Y_i is 1 at every bit. It does not depend on carry_i.
- R8: In arithmetic mode, carry_o equals grp_gen_o | (grp_prop_o & carry_i).
- R9: In arithmetic mode, carry_i = 0 adds nothing: f_o is the low bits of X + Y.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| sel_i | input | 4 | Function code |
| mode_i | input | 1 | 1 = logic, 0 = arithmetic |
| carry_i | input | 1 | Carry into bit 0 (arithmetic mode only) |
| f_o | output | WIDTH | Result |
| carry_o | output | 1 | Ripple carry out of the top bit |
| grp_prop_o | output | 1 | Group propagate for external lookahead |
| grp_gen_o | output | 1 | Group generate for external lookahead |

## Verification
The bench builds the slice with the default WIDTH of 4. At that width every combination of both operands, all sixteen codes, both modes and both carry-in values is 16,384 vectors, so it runs them all. This covers every carry chain length, the all-ones propagate case, and each named arithmetic code at its wrap-around boundaries. It also shows that the group outputs never follow the carry input.

// File: rtl/alu4_pkg.sv
package alu4_pkg;

  typedef enum logic [3:0] {
    TRM_ZERO,
    TRM_ONES,
    TRM_A,
    TRM_A_OR_B,
    TRM_A_OR_NB,
    TRM_A_AND_B,
    TRM_A_AND_NB,
    TRM_B,
    TRM_NB
  } term_e;

  typedef struct packed {
    term_e x;
    term_e y;
  } term_pair_t;

  // arithmetic code -> (X, Y) term kinds
  function automatic term_pair_t arith_terms(logic [3:0] code);
    term_pair_t t;
    case (code)
      4'b0000: t = '{TRM_A,        TRM_ZERO};
      4'b0001: t = '{TRM_A_OR_B,   TRM_ZERO};
      4'b0010: t = '{TRM_A_OR_NB,  TRM_ZERO};
      4'b0011: t = '{TRM_A,        TRM_A};
      4'b0100: t = '{TRM_A,        TRM_A_AND_B};
      4'b0101: t = '{TRM_A_OR_B,   TRM_A_AND_B};
      4'b0110: t = '{TRM_A,        TRM_B};
      4'b0111: t = '{TRM_A,        TRM_A_AND_NB};
      4'b1000: t = '{TRM_A_OR_B,   TRM_A_AND_NB};
      4'b1001: t = '{TRM_A,        TRM_NB};
      4'b1010: t = '{TRM_A_OR_NB,  TRM_A_AND_B};
      4'b1011: t = '{TRM_A_AND_B,  TRM_ONES};
      4'b1100: t = '{TRM_ZERO,     TRM_ONES};
      4'b1101: t = '{TRM_A_AND_NB, TRM_ONES};
      4'b1110: t = '{TRM_A_OR_NB,  TRM_A};
      default: t = '{TRM_A,        TRM_ONES};
    endcase
    return t;
  endfunction

  function automatic logic term_bit(term_e kind, logic a, logic b);
    logic r;
    case (kind)
      TRM_ZERO:     r = 1'b0;
      TRM_ONES:     r = 1'b1;
      TRM_A:        r = a;
      TRM_A_OR_B:   r = a | b;
      TRM_A_OR_NB:  r = a | ~b;
      TRM_A_AND_B:  r = a & b;
      TRM_A_AND_NB: r = a & ~b;
      TRM_B:        r = b;
      TRM_NB:       r = ~b;
      default:      r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/alu4_term_dec.sv
module alu4_term_dec
  import alu4_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [3:0]       sel_i,
  output logic [WIDTH-1:0] x_o,
  output logic [WIDTH-1:0] y_o
);

  term_pair_t pair;
  assign pair = arith_terms(sel_i);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign x_o[i] = term_bit(pair.x, a_i[i], b_i[i]);
    assign y_o[i] = term_bit(pair.y, a_i[i], b_i[i]);
  end

endmodule

// File: rtl/alu4_ripple.sv
module alu4_ripple #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             cin_i,
  input  logic             en_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);

  logic [WIDTH:0] c;
  // chain disabled -> no carry enters or leaves
  assign c[0] = cin_i & en_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    assign sum_o[i] = x_i[i] ^ y_i[i] ^ c[i];
    assign c[i+1]   = ((x_i[i] & y_i[i]) | ((x_i[i] | y_i[i]) & c[i])) & en_i;
  end

  assign cout_o = c[WIDTH];

endmodule

// File: rtl/alu4_group_pg.sv
module alu4_group_pg #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  output logic             pg_o,
  output logic             gg_o
);

  logic [WIDTH-1:0] p, g, gterm;

  assign p = x_i | y_i;
  assign g = x_i & y_i;

  // flat sum of products: g[i] qualified by all propagates above it
  for (genvar i = 0; i < WIDTH; i++) begin : g_term
    logic [WIDTH-1:0] hi_m;
    assign hi_m     = {WIDTH{1'b1}} << (i + 1);
    assign gterm[i] = g[i] & (&(p | ~hi_m));
  end

  assign gg_o = |gterm;
  assign pg_o = &p;

endmodule

// File: rtl/alu4_logic_unit.sv
module alu4_logic_unit #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [3:0]       sel_i,
  output logic [WIDTH-1:0] f_o
);

  // code is a truth table indexed by {a,b}
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign f_o[i] = sel_i[{a_i[i], b_i[i]}];
  end

endmodule

// File: rtl/alu4_lookahead.sv
module alu4_lookahead #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [3:0]       sel_i,
  input  logic             mode_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] f_o,
  output logic             carry_o,
  output logic             grp_prop_o,
  output logic             grp_gen_o
);

  logic [WIDTH-1:0] x, y, sum, lgc;
  logic             arith_en;

  assign arith_en = ~mode_i;

  alu4_term_dec #(.WIDTH(WIDTH)) u_dec (
    .a_i   (a_i),
    .b_i   (b_i),
    .sel_i (sel_i),
    .x_o   (x),
    .y_o   (y)
  );

  alu4_ripple #(.WIDTH(WIDTH)) u_rip (
    .x_i    (x),
    .y_i    (y),
    .cin_i  (carry_i),
    .en_i   (arith_en),
    .sum_o  (sum),
    .cout_o (carry_o)
  );

  alu4_group_pg #(.WIDTH(WIDTH)) u_grp (
    .x_i  (x),
    .y_i  (y),
    .pg_o (grp_prop_o),
    .gg_o (grp_gen_o)
  );

  alu4_logic_unit #(.WIDTH(WIDTH)) u_lgc (
    .a_i   (a_i),
    .b_i   (b_i),
    .sel_i (sel_i),
    .f_o   (lgc)
  );

  assign f_o = mode_i ? lgc : sum;

endmodule

// File: rtl/alu4_lookahead_chk.sv
module alu4_lookahead_chk #(
  parameter int WIDTH = 4
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [3:0]       sel_i,
  input logic             mode_i,
  input logic             carry_i,
  input logic [WIDTH-1:0] f_o,
  input logic             carry_o,
  input logic             grp_prop_o,
  input logic             grp_gen_o
);

  logic [WIDTH:0] add_ci, add_nc;

  assign add_ci = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, carry_i};
  assign add_nc = {1'b0, a_i} + {1'b0, b_i};

  always_comb begin
    // R2
    logic_cout_zero_chk: assert (!mode_i || !carry_o);
    // R8
    cout_lookahead_chk: assert (mode_i || carry_o == (grp_gen_o | (grp_prop_o & carry_i)));
    // R4
    add_code_chk: assert (mode_i || sel_i != 4'b0110 || {carry_o, f_o} == add_ci);
    // R4
    minus_one_chk: assert (mode_i || sel_i != 4'b1100 || carry_i || f_o == {WIDTH{1'b1}});
    // R6
    add_gen_chk: assert (sel_i != 4'b0110 || grp_gen_o == add_nc[WIDTH]);
    // R7
    add_prop_chk: assert (sel_i != 4'b0110 || grp_prop_o == &(a_i | b_i));
    for (int i = 0; i < WIDTH; i++) begin
      // R1
      logic_truth_chk: assert (!mode_i || f_o[i] == sel_i[{a_i[i], b_i[i]}]);
    end
  end

endmodule

bind alu4_lookahead alu4_lookahead_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i        (a_i),
  .b_i        (b_i),
  .sel_i      (sel_i),
  .mode_i     (mode_i),
  .carry_i    (carry_i),
  .f_o        (f_o),
  .carry_o    (carry_o),
  .grp_prop_o (grp_prop_o),
  .grp_gen_o  (grp_gen_o)
);

// File: tb/sim_alu4_lookahead.sv
`timescale 1ns/1ps
module sim_alu4_lookahead;

  localparam int W = 4;

  typedef struct packed {
    logic [3:0] a, b, s;
    logic       m, cn;
    logic [3:0] f;
    logic       c4, pg, gg;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [W-1:0] a, b, f;
  logic [3:0]   s;
  logic         m, cn, c4, pg, gg;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  item_t sb_q[$];

  alu4_lookahead #(.WIDTH(W)) u0 (
    .a_i(a), .b_i(b), .sel_i(s), .mode_i(m), .carry_i(cn),
    .f_o(f), .carry_o(c4), .grp_prop_o(pg), .grp_gen_o(gg)
  );

  // reference terms per arithmetic code (R3)
  function automatic void ref_xy(input int code, input int av, input int bv,
                                 output int x, output int y);
    int nb;
    nb = (~bv) & 15;
    case (code)
      0:  begin x = av;       y = 0;       end
      1:  begin x = av | bv;  y = 0;       end
      2:  begin x = av | nb;  y = 0;       end
      3:  begin x = av;       y = av;      end
      4:  begin x = av;       y = av & bv; end
      5:  begin x = av | bv;  y = av & bv; end
      6:  begin x = av;       y = bv;      end
      7:  begin x = av;       y = av & nb; end
      8:  begin x = av | bv;  y = av & nb; end
      9:  begin x = av;       y = nb;      end
      10: begin x = av | nb;  y = av & bv; end
      11: begin x = av & bv;  y = 15;      end
      12: begin x = 0;        y = 15;      end
      13: begin x = av & nb;  y = 15;      end
      14: begin x = av | nb;  y = av;      end
      default: begin x = av;  y = 15;      end
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input int av, input int bv, input int code, input bit mv, input bit cv);
    item_t it;
    int x, y, sum, lf;
    @(posedge clk);
    #1;
    a = av[3:0]; b = bv[3:0]; s = code[3:0]; m = mv; cn = cv;
    ref_xy(code, av, bv, x, y);
    sum = x + y + int'(cv);
    lf = 0;
    for (int i = 0; i < 4; i++)
      if (code[(av[i] ? 2 : 0) + (bv[i] ? 1 : 0)]) lf |= (1 << i);
    it.a = av[3:0]; it.b = bv[3:0]; it.s = code[3:0]; it.m = mv; it.cn = cv;
    it.f  = mv ? lf[3:0] : sum[3:0];
    it.c4 = mv ? 1'b0 : sum[4];
    it.gg = ((x + y) >> 4) != 0;
    it.pg = ((x | y) & 15) == 15;
    sb_q.push_back(it);
  endtask

  always @(negedge clk) begin
    if (rst_n && sb_q.size() > 0) begin
      item_t it;
      int nv;
      it = sb_q.pop_front();
      if (it.m) begin
        chk("R1", "f logic", f, it.f);
        chk("R2", "cout logic", c4, 0);
      end else begin
        chk(it.cn ? "R3" : "R9", "f arith", f, it.f);
        chk("R5", "cout arith", c4, it.c4);
        chk("R8", "cout vs group", c4, gg | (pg & it.cn));
        if (!it.cn) begin
          nv = -1;
          case (it.s)
            4'b0110: nv = (it.a + it.b) & 15;
            4'b1001: nv = (it.a - it.b - 1) & 15;
            4'b0011: nv = (2 * it.a) & 15;
            4'b1100: nv = 15;
            4'b1111: nv = (it.a - 1) & 15;
            default: nv = -1;
          endcase
          if (nv >= 0) chk("R4", "named code", f, nv);
        end
      end
      chk("R6", "group gen", gg, it.gg);
      chk("R7", "group prop", pg, it.pg);
    end
  end

  initial begin
    a = '0; b = '0; s = '0; m = 1'b1; cn = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "reset f", f, 0);
    chk("R2", "reset cout", c4, 0);
    chk("R6", "reset gg", gg, 0);
    chk("R7", "reset pg", pg, 0);
    rst_n = 1'b1;
    for (int mv = 0; mv < 2; mv++)
      for (int code = 0; code < 16; code++)
        for (int av = 0; av < 16; av++)
          for (int bv = 0; bv < 16; bv++)
            for (int cv = 0; cv < 2; cv++)
              drive(av, bv, code, mv[0], cv[0]);
    repeat (3) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule